// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion around a comparator and a trial DAC, both of which sit outside it. A start request first closes the sample switch for a programmable number of system clocks, so the hold capacitor can track the input. The switch then opens and the block searches for the code from the most significant bit downward, one bit per bit-time. The bit-time is a selectable multiple of the system clock.

When the last bit is decided, the code is written into two 8-bit result registers, either left- or right-justified. A one-cycle done pulse marks that write. The busy indication stays high from the accepted start until the write. Dropping the enable input abandons a conversion at once and keeps the previous result.

Top module: `sar_seq`

## Requirements
- R1: During and after synchronous reset, busy_o, done_o, sample_o, trial_o, res_hi_o and res_lo_o are all zero.
- R2: In the first conversion cycle trial_o is 10'h200, with only bit 9 set. At each decision, the bit under test stays 1 if cmp_i is 1 (input at or above the trial level) and is cleared otherwise. The next lower bit is then set for the following trial. After bit 0 is decided the code is final.
- R3: Each trial is held on trial_o for one bit-time. The bit-time is 2 clocks for div_sel_i=0, 8 for 1, and 32 for 2 or 3. The select is captured when the start is accepted.
- R4: sample_o is high for exactly acq_len_i cycles, with a value of 0 counting as 1. These cycles begin the cycle after the start is accepted. sample_o is low for the whole conversion phase. busy_o lasts acquisition plus 10 bit-times.
- R5: With left_just_i=0 captured at start (right-justified), res_hi_o = {6'b0, code[9:8]} and res_lo_o = code[7:0].
- R6: With left_just_i=1 captured at start (left-justified), res_hi_o = code[9:2] and res_lo_o = {code[1:0], 6'b0}.
- R7: busy_o rises the cycle after an accepted start. The result registers take the new code in the cycle when busy_o falls, and done_o is high for exactly that one cycle. The result registers change at no other time.
- R8: go_i asserted while busy_o is high is ignored: the running conversion neither restarts nor changes length.
- R9: With en_i low, the next cycle shows busy_o, sample_o, trial_o and done_o at zero and the result registers unchanged. A go_i seen while en_i is low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; low aborts and holds idle |
| go_i | input | 1 | Start request, accepted only when idle and enabled |
| div_sel_i | input | 2 | Bit-time select: 0=2, 1=8, 2/3=32 clocks |
| left_just_i | input | 1 | 1 selects left-justified result |
| acq_len_i | input | ACQ_W | Acquisition length in clocks (0 treated as 1) |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial level |
| trial_o | output | 10 | Trial code to the DAC (zero outside conversion) |
| sample_o | output | 1 | Sample switch closed (tracking) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when results are written |
| res_hi_o | output | 8 | High result register |
| res_lo_o | output | 8 | Low result register |

## Verification
A wrong phase or a wrong acquisition counter shows up at once at the ports. sample_o, busy_o or trial_o differ from the bench model in the first cycle where the internal state went wrong. A wrong bit index or a wrong decision shows up on trial_o no later than the next bit-time. This is well before the packed result reaches res_hi_o and res_lo_o at the end. Errors in the bit-time divider or in the captured justification show up as a trial step in the wrong cycle, or as a mispacked word in the done cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAR_BITS = 10;
    localparam int REG_W    = 8;
    localparam int TICK_W   = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } res_pair_t;

    function automatic logic [TICK_W-1:0] bit_time(input logic [1:0] sel);
        case (sel)
            2'd0:    bit_time = TICK_W'(2);
            2'd1:    bit_time = TICK_W'(8);
            default: bit_time = TICK_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tick_o = !clear_i && (cnt_q == period_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] code_o,
    output logic         last_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0]     trial_q;
    logic [IDX_W-1:0] idx_q;
    logic [N-1:0]     decided;

    always_comb begin
        decided        = trial_q;
        decided[idx_q] = cmp_i;
    end

    assign trial_o = trial_q;
    assign code_o  = decided;
    assign last_o  = (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            trial_q <= ONE << (N - 1);
            idx_q   <= IDX_W'(N - 1);
        end else if (step_i) begin
            trial_q <= decided | ((ONE << idx_q) >> 1);
            if (idx_q != '0) begin
                idx_q <= idx_q - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/sar_pack.sv
module sar_pack
    import sar_pkg::*;
#(
    parameter int N = 10,
    parameter int W = 8
) (
    input  logic         left_i,
    input  logic [N-1:0] code_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int WW  = 2 * W;
    localparam int PAD = WW - N;

    logic [WW-1:0] word;

    always_comb begin
        if (left_i) begin
            word = {code_i, {PAD{1'b0}}};
        end else begin
            word = {{PAD{1'b0}}, code_i};
        end
    end

    assign hi_o = word[WW-1:W];
    assign lo_o = word[W-1:0];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int ACQ_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                go_i,
    input  logic [1:0]          div_sel_i,
    input  logic                left_just_i,
    input  logic [ACQ_W-1:0]    acq_len_i,
    input  logic                cmp_i,
    output logic [SAR_BITS-1:0] trial_o,
    output logic                sample_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [REG_W-1:0]    res_hi_o,
    output logic [REG_W-1:0]    res_lo_o
);
    phase_e              phase_q;
    logic [ACQ_W-1:0]    acq_cnt_q;
    logic [TICK_W-1:0]   period_q;
    logic                left_q;
    res_pair_t           res_q;
    res_pair_t           res_new;
    logic                done_q;

    logic                tick;
    logic                last_bit;
    logic                load;
    logic                step;
    logic [SAR_BITS-1:0] trial_raw;
    logic [SAR_BITS-1:0] code_now;

    assign load = en_i && (phase_q == PH_ACQ) && (acq_cnt_q == ACQ_W'(1));
    assign step = en_i && (phase_q == PH_CONV) && tick;

    sar_tick_gen #(.CNT_W(TICK_W)) i_tick (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (phase_q != PH_CONV),
        .period_i (period_q),
        .tick_o   (tick)
    );

    sar_search #(.N(SAR_BITS)) i_search (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .step_i  (step),
        .cmp_i   (cmp_i),
        .trial_o (trial_raw),
        .code_o  (code_now),
        .last_o  (last_bit)
    );

    sar_pack #(.N(SAR_BITS), .W(REG_W)) i_pack (
        .left_i (left_q),
        .code_i (code_now),
        .hi_o   (res_new.hi),
        .lo_o   (res_new.lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            acq_cnt_q <= '0;
            period_q  <= '0;
            left_q    <= 1'b0;
            res_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en_i) begin
                phase_q <= PH_IDLE;
            end else begin
                case (phase_q)
                    PH_IDLE: begin
                        if (go_i) begin
                            phase_q   <= PH_ACQ;
                            acq_cnt_q <= (acq_len_i == '0) ? ACQ_W'(1) : acq_len_i;
                            period_q  <= bit_time(div_sel_i);
                            left_q    <= left_just_i;
                        end
                    end
                    PH_ACQ: begin
                        if (acq_cnt_q == ACQ_W'(1)) begin
                            phase_q <= PH_CONV;
                        end else begin
                            acq_cnt_q <= acq_cnt_q - ACQ_W'(1);
                        end
                    end
                    PH_CONV: begin
                        if (tick && last_bit) begin
                            phase_q <= PH_IDLE;
                            res_q   <= res_new;
                            done_q  <= 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign trial_o  = (phase_q == PH_CONV) ? trial_raw : '0;
    assign sample_o = (phase_q == PH_ACQ);
    assign busy_o   = (phase_q != PH_IDLE);
    assign done_o   = done_q;
    assign res_hi_o = res_q.hi;
    assign res_lo_o = res_q.lo;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic [9:0] trial_o,
    input logic       sample_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] res_hi_o,
    input logic [7:0] res_lo_o
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R7

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o))); // R7

    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> busy_o); // R4

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (rst)
        ($fell(sample_o) && busy_o) |-> (trial_o == 10'h200)); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!busy_o && !done_o && !sample_o && trial_o == 10'h000)); // R9

    AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(res_hi_o) && $stable(res_lo_o))); // R9
endmodule

bind sar_seq sar_seq_chk i_sar_seq_chk (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .trial_o  (trial_o),
    .sample_o (sample_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic       go  = 1'b0;
    logic [1:0] dsel = 2'd0;
    logic       ljust = 1'b0;
    logic [7:0] acq = 8'd1;
    logic       cmp;
    logic [9:0] trial;
    logic       sample, busy, done;
    logic [7:0] rhi, rlo;

    int vin = 0;
    int errs = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign cmp = (vin >= int'(trial));

    sar_seq i_sar_seq (
        .clk(clk), .rst(rst), .en_i(en), .go_i(go), .div_sel_i(dsel),
        .left_just_i(ljust), .acq_len_i(acq), .cmp_i(cmp), .trial_o(trial),
        .sample_o(sample), .busy_o(busy), .done_o(done),
        .res_hi_o(rhi), .res_lo_o(rlo)
    );

    // Behavioural reference model
    int m_ph = 0, m_acq = 0, m_d = 2, m_left = 0, m_trial = 0, m_bit = 0, m_tc = 0;
    int m_hi = 0, m_lo = 0, m_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_hi = 0; m_lo = 0; m_done = 0; m_trial = 0;
        end else begin
            m_done = 0;
            if (!en) begin
                m_ph = 0;
            end else if (m_ph == 0) begin
                if (go) begin
                    m_ph = 1;
                    m_acq = (acq == 0) ? 1 : int'(acq);
                    m_d = (dsel == 0) ? 2 : (dsel == 1) ? 8 : 32;
                    m_left = int'(ljust);
                end
            end else if (m_ph == 1) begin
                m_acq--;
                if (m_acq == 0) begin
                    m_ph = 2; m_trial = 512; m_bit = 9; m_tc = 0;
                end
            end else begin
                m_tc++;
                if (m_tc == m_d) begin
                    m_tc = 0;
                    if (!(vin >= m_trial)) m_trial -= (1 << m_bit);
                    if (m_bit == 0) begin
                        if (m_left != 0) begin
                            m_hi = m_trial / 4; m_lo = (m_trial % 4) * 64;
                        end else begin
                            m_hi = m_trial / 256; m_lo = m_trial % 256;
                        end
                        m_ph = 0; m_done = 1;
                    end else begin
                        m_bit--;
                        m_trial += (1 << m_bit);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 busy", int'(busy), (m_ph != 0) ? 1 : 0);
            chk("R7 done", int'(done), m_done);
            chk("R4 sample", int'(sample), (m_ph == 1) ? 1 : 0);
            chk("R2/R3 trial", int'(trial), (m_ph == 2) ? m_trial : 0);
            chk((m_left != 0) ? "R6 res_hi" : "R5 res_hi", int'(rhi), m_hi);
            chk((m_left != 0) ? "R6 res_lo" : "R5 res_lo", int'(rlo), m_lo);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL R7 watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic convert(input int v, input int sel, input int a, input int left, input int poke);
        int n = 0;
        int d = (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
        int ea = (a == 0) ? 1 : a;
        @(negedge clk);
        vin = v; dsel = 2'(sel); acq = 8'(a); ljust = left[0]; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
            go = (poke != 0 && (n == 4 || n == ea + 3)) ? 1'b1 : 1'b0;
            dsel = 2'd0; ljust = ~ljust;   // changes after start must not matter (R3)
        end
        go = 1'b0;
        chk(poke != 0 ? "R8 busy length" : "R4 busy length", n, ea + 10 * d);
        chk("R7 done at end", int'(done), 1);
        if (left != 0) begin
            chk("R6 hi", int'(rhi), v / 4);
            chk("R6 lo", int'(rlo), (v % 4) * 64);
        end else begin
            chk("R5 hi", int'(rhi), v / 256);
            chk("R5 lo", int'(rlo), v % 256);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 sample", int'(sample), 0);
        chk("R1 trial", int'(trial), 0);
        chk("R1 res", int'({rhi, rlo}), 0);
        rst = 1'b0;

        convert(10'h2A5, 0, 3, 0, 0);
        convert(10'h3FF, 1, 0, 1, 0);
        convert(0, 2, 5, 0, 0);
        convert(10'h155, 3, 2, 1, 0);
        convert(10'h200, 0, 1, 0, 0);
        convert(10'h1FF, 1, 4, 1, 1);   // R8: go pokes while busy
        convert(10'h001, 0, 2, 0, 1);

        // R9: abort in the middle of a conversion
        begin
            int sh, sl;
            sh = int'(rhi); sl = int'(rlo);
            @(negedge clk);
            vin = 700; dsel = 2'd1; acq = 8'd2; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            repeat (9) @(negedge clk);
            en = 1'b0;
            @(negedge clk);
            chk("R9 busy after abort", int'(busy), 0);
            chk("R9 trial after abort", int'(trial), 0);
            chk("R9 res kept", int'({rhi, rlo}), (sh << 8) | sl);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            @(negedge clk);
            chk("R9 go ignored while disabled", int'(busy), 0);
            en = 1'b1;
            repeat (3) @(negedge clk);
            chk("R9 still idle", int'(busy), 0);
            chk("R9 res still kept", int'({rhi, rlo}), (sh << 8) | sl);
        end

        convert(10'h333, 2, 1, 1, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule